// File: doc/BRIEF.md
# Locked-Rotor Fault Detector

This block watches the three Hall sensors of a three-phase brushless motor and decides when the rotor has stalled. A free-running timeout counter advances on each pulse of a timebase tick input. The tick stands in for the cycles of a slow external timing oscillator. Each time the Hall code passes through three distinct valid states in a row, the rotor has made real forward progress and the counter returns to zero.

A rotor that has stopped produces no Hall edges, so nothing clears the counter. A rotor that only rocks back and forth between two Hall states produces edges but never a third distinct state, so nothing clears the counter either. In both cases the count reaches the lock limit, and the block then latches a fault and raises a drive-off signal for the gate drivers.

Only three events release the latched fault:
- either edge of the direction input,
- an enable input held high for a long, configurable number of clock cycles,
- the power-up reset.

Brake and a detection-off input hold the counter at zero. The block also generates two tachometer toggle outputs from the Hall inputs.

Top module: `rotor_lock_guard`

## Requirements
- R1: `tachAll` starts at 0 after reset and inverts once for every individual Hall bit that changes. It therefore inverts when an odd number of bits change between two settled codes, and keeps its value otherwise.
- R2: `tachA` starts at 0 after reset and inverts on every change of Hall bit 0 (`hallIn[0]`, sensor A), whatever the other two bits do.
- R3: While the block is running, each `tickIn` pulse advances the timeout count, which saturates at LOCK_TICKS (default 127). `driveOff` rises within three clock cycles after the count reaches LOCK_TICKS, and not after LOCK_TICKS-1 pulses.
- R4: A Hall change to a valid code that differs from both of the two previously recorded valid codes counts as progress and sets the timeout count back to zero.
- R5: A rotor that alternates between two valid Hall codes never counts as progress, so the ticks keep accumulating towards the fault.
- R6: Hall codes 000 and 111 are invalid. They never count as progress and never enter the recorded history.
- R7: Once `driveOff` is high, it stays high through ticks, Hall progress, brake and detection-off, until a clear event occurs.
- R8: A rising or a falling edge of `dirIn` clears `driveOff`, the timeout count and the Hall history.
- R9: Holding `enIn` high for EN_HOLD_CYCLES clock cycles (after synchronization) clears `driveOff`, the count and the history. A shorter high pulse has no effect.
- R10: While `brakeIn` is high, the timeout count is held at zero.
- R11: While `detectOff` is high, the timeout count is held at zero and no new fault can latch.
- R12: Asserting `rstN` low clears `driveOff`, `tachAll` and `tachA`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-up reset |
| hallIn | input | 3 | Raw Hall sensor inputs; bit 0 is sensor A |
| tickIn | input | 1 | One-cycle timebase pulse, one per oscillator cycle |
| dirIn | input | 1 | Direction input; either edge clears a fault |
| enIn | input | 1 | Enable input; a long high level clears a fault |
| brakeIn | input | 1 | Brake active; holds the timeout count at zero |
| detectOff | input | 1 | Disables lock detection |
| driveOff | output | 1 | Latched locked-rotor fault; disables the drivers |
| tachAll | output | 1 | Toggles on every Hall bit transition |
| tachA | output | 1 | Toggles on every sensor-A transition |

## Verification
The hardest condition to reach from the ports is the rotor that keeps producing Hall edges yet never advances. Here the counter must keep running while the edges arrive, and it must still stop exactly at the limit.

The stimulus therefore first clears the history with a direction edge. It then records two codes and alternates between them, placing tick bursts between the steps, so that the lock lands on a known tick. The same approach, with invalid codes inserted between valid ones, shows that 000 and 111 cannot stand in for a third state.

An exhaustive sweep of tick counts either side of the limit pins down the exact threshold. A sweep of all 64 Hall code pairs checks both tachometer outputs.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic cntClr;   // zero the timeout count
    logic cntInc;   // advance the timeout count by one
    logic histClr;  // forget the recorded Hall states
  } rlgStrobe_t;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_PAUSE  = 2'd1,
    ST_LOCKED = 2'd2
  } rlgState_t;

  // Codes 000 and 111 never occur on a healthy sensor set.
  function automatic logic hallCodeValid(input logic [2:0] code);
    return (code != 3'b000) && (code != 3'b111);
  endfunction

endpackage

// File: rtl/rlg_sync.sv
module rlg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= dIn;
      for (int i = 1; i < STAGES; i++) begin
        stage[i] <= stage[i-1];
      end
    end
  end

  assign qOut = stage[STAGES-1];

endmodule

// File: rtl/rlg_datapath.sv
module rlg_datapath
  import rlg_pkg::*;
#(
  parameter int LOCK_TICKS     = 127,
  parameter int EN_HOLD_CYCLES = 375000,
  parameter int SYNC_STAGES    = 2,
  localparam int CNT_W         = $clog2(LOCK_TICKS + 1),
  localparam int EN_W          = $clog2(EN_HOLD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       hallIn,
  input  logic             dirIn,
  input  logic             enIn,
  input  rlgStrobe_t       strobe,
  output logic             tachAll,
  output logic             tachA,
  output logic             progress,
  output logic             cntFull,
  output logic             dirEdge,
  output logic             enLong,
  output logic [CNT_W-1:0] lockCnt
);

  localparam int SYNC_W = 5;

  logic [SYNC_W-1:0] syncQ;
  logic [2:0]        hallNow;
  logic [2:0]        hallPrev;
  logic [2:0]        hallDelta;
  logic              hallChg;
  logic              dirNow;
  logic              dirPrev;
  logic              enNow;
  logic [EN_W-1:0]   enCnt;
  logic [2:0]        histLast;   // most recent valid code, 0 = empty
  logic [2:0]        histPrior;  // valid code before that, 0 = empty
  logic              newValid;

  // All pin inputs cross into the clock domain together.
  rlg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({enIn, dirIn, hallIn}),
    .qOut (syncQ)
  );

  assign hallNow = syncQ[2:0];
  assign dirNow  = syncQ[3];
  assign enNow   = syncQ[4];

  assign hallDelta = hallNow ^ hallPrev;
  assign hallChg   = |hallDelta;
  assign dirEdge   = dirNow ^ dirPrev;
  assign newValid  = hallChg && hallCodeValid(hallNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hallPrev <= '0;
      dirPrev  <= 1'b0;
      tachAll  <= 1'b0;
      tachA    <= 1'b0;
    end else begin
      hallPrev <= hallNow;
      dirPrev  <= dirNow;
      // One inversion per changed bit: odd counts flip, even counts cancel.
      tachAll  <= tachAll ^ (^hallDelta);
      tachA    <= tachA ^ hallDelta[0];
    end
  end

  // Forward progress: a third valid code distinct from the two before it.
  assign progress = newValid && (histLast != 3'b000) && (histPrior != 3'b000) &&
                    (hallNow != histLast) && (hallNow != histPrior);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histLast  <= '0;
      histPrior <= '0;
    end else if (strobe.histClr) begin
      histLast  <= '0;
      histPrior <= '0;
    end else if (newValid && (hallNow != histLast)) begin
      histPrior <= histLast;
      histLast  <= hallNow;
    end
  end

  // Timeout counter, saturating at the lock limit.
  assign cntFull = (lockCnt == CNT_W'(LOCK_TICKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt <= '0;
    end else if (strobe.cntClr) begin
      lockCnt <= '0;
    end else if (strobe.cntInc && !cntFull) begin
      lockCnt <= lockCnt + 1'b1;
    end
  end

  // Enable-high duration; pulses once when the hold length is reached.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enCnt <= '0;
    end else if (!enNow) begin
      enCnt <= '0;
    end else if (enCnt != EN_W'(EN_HOLD_CYCLES)) begin
      enCnt <= enCnt + 1'b1;
    end
  end

  assign enLong = enNow && (enCnt == EN_W'(EN_HOLD_CYCLES - 1));

endmodule

// File: rtl/rlg_control.sv
module rlg_control
  import rlg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       brakeIn,
  input  logic       detectOff,
  input  logic       progress,
  input  logic       cntFull,
  input  logic       dirEdge,
  input  logic       enLong,
  output rlgStrobe_t strobe,
  output logic       driveOff
);

  rlgState_t state;
  rlgState_t stateNext;
  logic      clearEvt;
  logic      pauseReq;

  assign clearEvt = dirEdge || enLong;
  assign pauseReq = brakeIn || detectOff;

  // Priority: clear event, then latched fault, then pause, then timeout.
  always_comb begin
    stateNext = state;
    if (clearEvt) begin
      stateNext = pauseReq ? ST_PAUSE : ST_RUN;
    end else if (state == ST_LOCKED) begin
      stateNext = ST_LOCKED;
    end else if (pauseReq) begin
      stateNext = ST_PAUSE;
    end else if (state == ST_RUN && cntFull && !progress) begin
      stateNext = ST_LOCKED;
    end else begin
      stateNext = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    strobe.cntClr  = clearEvt || pauseReq || progress;
    strobe.cntInc  = (state == ST_RUN) && tickIn && !pauseReq;
    strobe.histClr = clearEvt;
  end

  assign driveOff = (state == ST_LOCKED);

endmodule

// File: rtl/rotor_lock_guard.sv
module rotor_lock_guard
  import rlg_pkg::*;
#(
  parameter int LOCK_TICKS     = 127,
  parameter int EN_HOLD_CYCLES = 375000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hallIn,
  input  logic       tickIn,
  input  logic       dirIn,
  input  logic       enIn,
  input  logic       brakeIn,
  input  logic       detectOff,
  output logic       driveOff,
  output logic       tachAll,
  output logic       tachA
);

  localparam int CNT_W = $clog2(LOCK_TICKS + 1);

  rlgStrobe_t       strobe;
  logic             progress;
  logic             cntFull;
  logic             dirEdge;
  logic             enLong;
  logic [CNT_W-1:0] lockCnt;

  rlg_datapath #(
    .LOCK_TICKS     (LOCK_TICKS),
    .EN_HOLD_CYCLES (EN_HOLD_CYCLES),
    .SYNC_STAGES    (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .hallIn   (hallIn),
    .dirIn    (dirIn),
    .enIn     (enIn),
    .strobe   (strobe),
    .tachAll  (tachAll),
    .tachA    (tachA),
    .progress (progress),
    .cntFull  (cntFull),
    .dirEdge  (dirEdge),
    .enLong   (enLong),
    .lockCnt  (lockCnt)
  );

  rlg_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .tickIn    (tickIn),
    .brakeIn   (brakeIn),
    .detectOff (detectOff),
    .progress  (progress),
    .cntFull   (cntFull),
    .dirEdge   (dirEdge),
    .enLong    (enLong),
    .strobe    (strobe),
    .driveOff  (driveOff)
  );

endmodule

// File: rtl/rlg_checker.sv
module rlg_checker #(
  parameter int LOCK_TICKS = 127,
  localparam int CNT_W     = $clog2(LOCK_TICKS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             brakeIn,
  input logic             detectOff,
  input logic             driveOff,
  input logic [CNT_W-1:0] cnt,
  input logic             dirEdge,
  input logic             enLong
);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(LOCK_TICKS));

  assert_lock_at_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveOff) |-> ($past(cnt) == CNT_W'(LOCK_TICKS)));

  assert_fault_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (driveOff && !dirEdge && !enLong) |=> driveOff);

  assert_dir_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    dirEdge |=> (!driveOff && cnt == '0));

  assert_en_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    enLong |=> (!driveOff && cnt == '0));

  assert_pause_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (brakeIn || detectOff) |=> (cnt == '0));

  assert_off_no_fault_R11: assert property (@(posedge clk) disable iff (!rstN)
    (detectOff && !driveOff) |=> !driveOff);

endmodule

bind rotor_lock_guard rlg_checker #(.LOCK_TICKS(LOCK_TICKS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .brakeIn   (brakeIn),
  .detectOff (detectOff),
  .driveOff  (driveOff),
  .cnt       (lockCnt),
  .dirEdge   (dirEdge),
  .enLong    (enLong)
);

// File: tb/rotor_lock_guard_tb.sv
module rotor_lock_guard_tb;

  localparam int LIMIT   = 127;
  localparam int EN_HOLD = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hallIn = 3'b000;
  logic       tickIn = 1'b0;
  logic       dirIn = 1'b0;
  logic       enIn = 1'b0;
  logic       brakeIn = 1'b0;
  logic       detectOff = 1'b0;
  logic       driveOff;
  logic       tachAll;
  logic       tachA;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  rotor_lock_guard #(
    .LOCK_TICKS     (LIMIT),
    .EN_HOLD_CYCLES (EN_HOLD),
    .SYNC_STAGES    (2)
  ) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .hallIn    (hallIn),
    .tickIn    (tickIn),
    .dirIn     (dirIn),
    .enIn      (enIn),
    .brakeIn   (brakeIn),
    .detectOff (detectOff),
    .driveOff  (driveOff),
    .tachAll   (tachAll),
    .tachA     (tachA)
  );

  task automatic chk(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tickIn = 1'b1;
      @(negedge clk) tickIn = 1'b0;
    end
    idle(3);
  endtask

  task automatic setHall(input logic [2:0] code);
    @(negedge clk) hallIn = code;
    idle(6);
  endtask

  task automatic flipDir();
    @(negedge clk) dirIn = ~dirIn;
    idle(6);
  endtask

  // Leave the Hall code on 5, then clear with a direction edge.
  task automatic freshStart();
    setHall(3'd5);
    flipDir();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic ta0, tb0;
    idle(4);
    @(negedge clk) rstN = 1'b1;
    // R12 reset state
    chk(driveOff, 0, "R12 driveOff after reset");
    chk(tachAll, 0, "R12 tachAll after reset");
    chk(tachA, 0, "R12 tachA after reset");

    // R3 threshold sweep; every clear uses alternating dir edges (R8).
    for (int n = 1; n <= LIMIT + 3; n++) begin
      flipDir();
      chk(driveOff, 0, dirIn ? "R8 rising dir clear" : "R8 falling dir clear");
      ticks(n);
      chk(driveOff, (n >= LIMIT) ? 1 : 0, "R3 lock after tick count");
    end

    // R7: fault survives ticks, brake and Hall progress
    setHall(3'd1); setHall(3'd3); setHall(3'd2); setHall(3'd6);
    ticks(5);
    @(negedge clk) brakeIn = 1'b1;
    idle(4);
    @(negedge clk) brakeIn = 1'b0;
    idle(2);
    chk(driveOff, 1, "R7 fault held");

    // R4: progress restarts the count
    freshStart();
    setHall(3'd1); setHall(3'd3);
    ticks(100);
    setHall(3'd2);
    ticks(LIMIT - 1);
    chk(driveOff, 0, "R4 no lock after progress");
    ticks(1);
    chk(driveOff, 1, "R4 lock at limit after progress");

    // R5: rocking between two codes
    freshStart();
    setHall(3'd1); setHall(3'd3);
    for (int i = 0; i < 20; i++) begin
      setHall(3'd1); ticks(3);
      setHall(3'd3); ticks(3);
    end
    chk(driveOff, 0, "R5 rocking below limit");
    ticks(LIMIT - 120);
    chk(driveOff, 1, "R5 rocking reaches lock");

    // R6: invalid codes do not act as a third state
    freshStart();
    setHall(3'd1); setHall(3'd3);
    ticks(100);
    setHall(3'd0); setHall(3'd7); setHall(3'd3); setHall(3'd7);
    ticks(LIMIT - 101);
    chk(driveOff, 0, "R6 below limit with invalid codes");
    ticks(1);
    chk(driveOff, 1, "R6 invalid codes gave no progress");

    // R9: short enable pulse is ignored, long one clears
    @(negedge clk) enIn = 1'b1;
    idle(EN_HOLD - 10);
    @(negedge clk) enIn = 1'b0;
    idle(6);
    chk(driveOff, 1, "R9 short enable ignored");
    @(negedge clk) enIn = 1'b1;
    idle(EN_HOLD + 20);
    @(negedge clk) enIn = 1'b0;
    idle(6);
    chk(driveOff, 0, "R9 long enable clears");
    ticks(LIMIT - 1);
    chk(driveOff, 0, "R9 count cleared by enable");
    ticks(1);
    chk(driveOff, 1, "R9 relock at limit");

    // R10: brake zeroes the count
    flipDir();
    ticks(100);
    @(negedge clk) brakeIn = 1'b1;
    ticks(50);
    @(negedge clk) brakeIn = 1'b0;
    chk(driveOff, 0, "R10 no lock during brake");
    ticks(LIMIT - 1);
    chk(driveOff, 0, "R10 count restarted after brake");
    ticks(1);
    chk(driveOff, 1, "R10 lock after brake release");

    // R11: detection off
    flipDir();
    @(negedge clk) detectOff = 1'b1;
    ticks(2 * LIMIT);
    chk(driveOff, 0, "R11 no lock while disabled");
    @(negedge clk) detectOff = 1'b0;
    ticks(LIMIT - 1);
    chk(driveOff, 0, "R11 count held at zero");
    ticks(1);
    chk(driveOff, 1, "R11 lock after enable of detection");

    // R1 / R2: all 64 ordered Hall code pairs
    @(negedge clk) detectOff = 1'b1;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        setHall(3'(a));
        ta0 = tachAll;
        tb0 = tachA;
        setHall(3'(b));
        chk(int'(tachAll ^ ta0), int'(^(3'(a) ^ 3'(b))), "R1 tachAll parity");
        chk(int'(tachA ^ tb0), int'(((a ^ b) & 1) != 0), "R2 tachA on sensor A");
      end
    end
    @(negedge clk) detectOff = 1'b0;

    // R12: reset clears a latched fault
    flipDir();
    ticks(LIMIT);
    chk(driveOff, 1, "R12 locked before reset");
    setHall(3'd0);
    @(negedge clk) rstN = 1'b0;
    idle(3);
    @(negedge clk) rstN = 1'b1;
    chk(driveOff, 0, "R12 reset clears fault");
    chk(tachAll, 0, "R12 reset clears tachAll");
    chk(tachA, 0, "R12 reset clears tachA");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule